// File: doc/BRIEF.md
# External Bus Access Phase Sequencer

This block times one access to an external memory or peripheral. An access has three phases in a fixed order: lead, active and trail. The lengths of the phases are counted in interface clock cycles. They come from a timing word that belongs to the address zone being accessed. Each zone's timing word has one set of lead, active and trail counts for reads and a separate set for writes. It also has a double-timing bit and a bit that lets a ready input stretch the active phase.

The zone is decoded from the upper address bits when a request is taken in idle. The counts the zone and direction select are then held for the whole access. Chip-select is low from the first lead cycle to the last trail cycle. Only the read or the write strobe goes low, and only during the active phase. After the trail phase the block raises a one-cycle done pulse and returns to idle. Settings are not checked: a lead count of 0 is an illegal setting when ready is not used, but the block still runs it and skips the empty phase.

Top module: `xbus_phase_seq`

States and transitions (named `seq_state_e`):
- IDLE→LEAD on an accepted request with a non-zero lead length.
- IDLE→ACTIVE on an accepted request with a zero lead length.
- LEAD→ACTIVE when the lead count runs out.
- ACTIVE→ACTIVE (hold) while ready is in use and low on the last programmed active cycle.
- ACTIVE→TRAIL when active finishes and the trail length is non-zero.
- ACTIVE→DONE when active finishes and the trail length is zero.
- TRAIL→DONE when the trail count runs out.
- DONE→IDLE always, after one cycle.

## Requirements
- R1: Within an access, chip-select `cs_n` is low in one unbroken run covering lead, active and trail. The strobe is low in one unbroken run, with no lead cycle after it and no trail cycle before it.
- R2: With `req_wr`=1 the write fields are used and only `wr_n` pulses. With `req_wr`=0 the read fields are used and only `rd_n` pulses. The other strobe stays high for the whole access.
- R3: With the zone's double bit 0, lead lasts LEAD cycles, active lasts ACTIVE+WS+1 cycles and trail lasts TRAIL cycles.
- R4: With the zone's double bit 1, lead lasts 2×LEAD cycles, active lasts 2×ACTIVE+WS+1 cycles and trail lasts 2×TRAIL cycles. WS and the fixed cycle are not doubled.
- R5: With use-ready 1, `ready` is sampled at the end of the last programmed active cycle and of every cycle after it. Each low sample adds one active cycle (WS).
- R6: With use-ready 0, `ready` is ignored and WS is 0.
- R7: The zone is `req_zone`. Zone z's timing word is `zone_cfg[z*20 +: 20]`, laid out with FW=3 as follows:
  - bits 2:0 read lead
  - bits 5:3 read active
  - bits 8:6 read trail
  - bits 11:9 write lead
  - bits 14:12 write active
  - bits 17:15 write trail
  - bit 18 double
  - bit 19 use-ready
- R8: A phase whose length is 0 is skipped. With lead 0 the strobe is low in the first cycle of chip-select. With trail 0 the done pulse follows the last active cycle directly. Illegal settings are not rejected.
- R9: `done` is high for exactly one cycle: the first cycle after the last trail cycle. `cs_n` is high in that cycle and in the next one.
- R10: A request is taken only in idle. A request raised during an access changes neither that access nor starts a new one.
- R11: During reset and after it, `cs_n`, `rd_n` and `wr_n` are high and `done` is low. Reset during an access ends it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, taken in idle |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| req_zone | input | ZONE_W | Upper address bits that pick the zone |
| zone_cfg | input | NZONES*CFG_W | Timing words of all zones, zone 0 in the low bits |
| ready | input | 1 | Ready from the addressed device, high = ready |
| cs_n | output | 1 | Chip-select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
Accesses are run in both directions on four zones:
- The minimum 1/0/0 timing.
- Mixed single-timed counts.
- Doubled counts.
- Zero lead and trail counts.

Comparing single-timed and doubled zones separates the doubled phase counts from the undoubled fixed cycle. Varying the cycle in which `ready` rises tells a wait added on the last programmed cycle apart from one added earlier, or not added at all. Holding `ready` low on zones without use-ready shows it is ignored. A request raised in mid-access, and a reset in mid-access, test idle-only acceptance and the return to a safe state.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

    // Field positions inside one zone timing word, in units of FW bits
    localparam int F_RD_LEAD  = 0;
    localparam int F_RD_ACT   = 1;
    localparam int F_RD_TRAIL = 2;
    localparam int F_WR_LEAD  = 3;
    localparam int F_WR_ACT   = 4;
    localparam int F_WR_TRAIL = 5;
    localparam int NUM_FIELDS = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_ACTIVE,
        ST_TRAIL,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/xbus_zone_sel.sv
module xbus_zone_sel
    import xbus_seq_pkg::*;
#(
    parameter int NZONES = 4,
    parameter int FW     = 3,
    localparam int ZONE_W = $clog2(NZONES),
    localparam int CFG_W  = NUM_FIELDS * FW + 2,
    localparam int LW     = FW + 1
) (
    input  logic [ZONE_W-1:0]       zone,
    input  logic                    wr,
    input  logic [NZONES*CFG_W-1:0] zone_cfg,
    output logic [LW-1:0]           lead_len,
    output logic [LW-1:0]           act_len,
    output logic [LW-1:0]           trail_len,
    output logic                    use_rdy
);

    logic [CFG_W-1:0] cfg_arr [NZONES];
    logic [CFG_W-1:0] cfg;
    logic [FW-1:0]    lead_raw, act_raw, trail_raw;
    logic             dbl;

    for (genvar z = 0; z < NZONES; z++) begin : g_zone
        assign cfg_arr[z] = zone_cfg[z*CFG_W +: CFG_W];
    end

    assign cfg = cfg_arr[zone];

    always_comb begin
        if (wr) begin
            lead_raw  = cfg[F_WR_LEAD*FW  +: FW];
            act_raw   = cfg[F_WR_ACT*FW   +: FW];
            trail_raw = cfg[F_WR_TRAIL*FW +: FW];
        end else begin
            lead_raw  = cfg[F_RD_LEAD*FW  +: FW];
            act_raw   = cfg[F_RD_ACT*FW   +: FW];
            trail_raw = cfg[F_RD_TRAIL*FW +: FW];
        end
        dbl     = cfg[NUM_FIELDS*FW];
        use_rdy = cfg[NUM_FIELDS*FW + 1];
        // doubling scales only the programmed counts
        lead_len  = dbl ? {lead_raw, 1'b0}  : {1'b0, lead_raw};
        act_len   = dbl ? {act_raw, 1'b0}   : {1'b0, act_raw};
        trail_len = dbl ? {trail_raw, 1'b0} : {1'b0, trail_raw};
    end

endmodule

// File: rtl/xbus_phase_fsm.sv
module xbus_phase_fsm
    import xbus_seq_pkg::*;
#(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [LW-1:0] lead_len,
    input  logic [LW-1:0] act_len,
    input  logic [LW-1:0] trail_len,
    input  logic          use_rdy,
    input  logic          ready,
    output logic          cs_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          done
);

    seq_state_e    state, nxt_state;
    logic [LW-1:0] cnt, nxt_cnt;
    logic [LW-1:0] act_q, trail_q;
    logic          rdy_q, wr_q;

    // next state and phase counter
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (lead_len != '0) begin
                        nxt_state = ST_LEAD;
                        nxt_cnt   = lead_len - LW'(1);
                    end else begin
                        nxt_state = ST_ACTIVE;
                        nxt_cnt   = act_len;
                    end
                end
            end
            ST_LEAD: begin
                if (cnt != '0) begin
                    nxt_cnt = cnt - LW'(1);
                end else begin
                    nxt_state = ST_ACTIVE;
                    nxt_cnt   = act_q;
                end
            end
            ST_ACTIVE: begin
                if (cnt != '0) begin
                    nxt_cnt = cnt - LW'(1);
                end else if (rdy_q && !ready) begin
                    nxt_state = ST_ACTIVE;   // wait cycle
                end else if (trail_q != '0) begin
                    nxt_state = ST_TRAIL;
                    nxt_cnt   = trail_q - LW'(1);
                end else begin
                    nxt_state = ST_DONE;
                end
            end
            ST_TRAIL: begin
                if (cnt != '0) begin
                    nxt_cnt = cnt - LW'(1);
                end else begin
                    nxt_state = ST_DONE;
                end
            end
            ST_DONE: nxt_state = ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    // state register and per-access latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            act_q   <= '0;
            trail_q <= '0;
            rdy_q   <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            if (state == ST_IDLE && req) begin
                act_q   <= act_len;
                trail_q <= trail_len;
                rdy_q   <= use_rdy;
                wr_q    <= req_wr;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        cs_n = 1'b1;
        rd_n = 1'b1;
        wr_n = 1'b1;
        done = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_LEAD:   cs_n = 1'b0;
            ST_ACTIVE: begin
                cs_n = 1'b0;
                rd_n = wr_q;
                wr_n = !wr_q;
            end
            ST_TRAIL:  cs_n = 1'b0;
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/xbus_phase_seq.sv
module xbus_phase_seq
    import xbus_seq_pkg::*;
#(
    parameter int NZONES = 4,
    parameter int FW     = 3,
    localparam int ZONE_W = $clog2(NZONES),
    localparam int CFG_W  = NUM_FIELDS * FW + 2,
    localparam int LW     = FW + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    req_wr,
    input  logic [ZONE_W-1:0]       req_zone,
    input  logic [NZONES*CFG_W-1:0] zone_cfg,
    input  logic                    ready,
    output logic                    cs_n,
    output logic                    rd_n,
    output logic                    wr_n,
    output logic                    done
);

    logic [LW-1:0] lead_len, act_len, trail_len;
    logic          use_rdy;

    xbus_zone_sel #(
        .NZONES (NZONES),
        .FW     (FW)
    ) u_zone_sel (
        .zone      (req_zone),
        .wr        (req_wr),
        .zone_cfg  (zone_cfg),
        .lead_len  (lead_len),
        .act_len   (act_len),
        .trail_len (trail_len),
        .use_rdy   (use_rdy)
    );

    xbus_phase_fsm #(
        .LW (LW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .lead_len  (lead_len),
        .act_len   (act_len),
        .trail_len (trail_len),
        .use_rdy   (use_rdy),
        .ready     (ready),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .done      (done)
    );

endmodule

// File: rtl/xbus_phase_seq_chk.sv
module xbus_phase_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rd_n,
    input logic wr_n,
    input logic done
);

    // R2: never both strobes at once
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R1: a strobe only inside chip-select
    a_r1_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !cs_n);

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: chip-select released while done is high
    a_r9_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    // R9: end of chip-select is marked by done
    a_r9_cs_end_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);

    // R10: after done the sequencer is idle for a cycle
    a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cs_n);

endmodule

bind xbus_phase_seq xbus_phase_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .done  (done)
);

// File: tb/tb_xbus_phase_seq.sv
`timescale 1ns/1ps
module tb_xbus_phase_seq;

    localparam int NZ    = 4;
    localparam int FW    = 3;
    localparam int CFG_W = 6*FW + 2;

    // per-zone settings: read lead/act/trail, write lead/act/trail, double, use-ready
    localparam int Z_RL[NZ]  = '{1, 2, 1, 0};
    localparam int Z_RA[NZ]  = '{0, 3, 2, 0};
    localparam int Z_RT[NZ]  = '{0, 1, 3, 0};
    localparam int Z_WL[NZ]  = '{1, 3, 2, 0};
    localparam int Z_WA[NZ]  = '{0, 1, 0, 4};
    localparam int Z_WT[NZ]  = '{0, 2, 1, 0};
    localparam int Z_DBL[NZ] = '{0, 0, 1, 1};
    localparam int Z_RDY[NZ] = '{0, 1, 1, 0};

    // vector table: direction, zone, cycle count before ready rises
    localparam int VN = 10;
    localparam int V_WR[VN]   = '{0, 1, 0, 0, 1, 1, 0, 1, 0, 1};
    localparam int V_ZONE[VN] = '{0, 0, 1, 1, 1, 1, 2, 2, 3, 3};
    localparam int V_K[VN]    = '{0, 5, 0, 7, 2, 4, 0, 8, 0, 20};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req = 1'b0;
    logic                 req_wr = 1'b0;
    logic [1:0]           req_zone = '0;
    logic [NZ*CFG_W-1:0]  zone_cfg = '0;
    logic                 ready = 1'b1;
    logic                 cs_n, rd_n, wr_n, done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    xbus_phase_seq #(.NZONES(NZ), .FW(FW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .req_zone (req_zone),
        .zone_cfg (zone_cfg),
        .ready    (ready),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .done     (done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [CFG_W-1:0] pack_zone(input int z);
        logic [CFG_W-1:0] w;
        w = '0;
        w[0*FW +: FW] = FW'(Z_RL[z]);
        w[1*FW +: FW] = FW'(Z_RA[z]);
        w[2*FW +: FW] = FW'(Z_RT[z]);
        w[3*FW +: FW] = FW'(Z_WL[z]);
        w[4*FW +: FW] = FW'(Z_WA[z]);
        w[5*FW +: FW] = FW'(Z_WT[z]);
        w[6*FW]       = Z_DBL[z][0];
        w[6*FW+1]     = Z_RDY[z][0];
        return w;
    endfunction

    function automatic int e_lead(input int wr, input int z);
        int v = wr ? Z_WL[z] : Z_RL[z];
        return Z_DBL[z] ? 2*v : v;
    endfunction

    function automatic int e_trail(input int wr, input int z);
        int v = wr ? Z_WT[z] : Z_RT[z];
        return Z_DBL[z] ? 2*v : v;
    endfunction

    function automatic int e_act(input int wr, input int z, input int k);
        int v = wr ? Z_WA[z] : Z_RA[z];
        int a = (Z_DBL[z] ? 2*v : v) + 1;
        if (Z_RDY[z] != 0 && k > a) a = k;
        return a;
    endfunction

    // one access; ready rises once the strobe has been seen low k times
    task automatic run_access(input int wr, input int zone, input int k, input bit inject,
                              output int lead, output int act, output int trail,
                              output bit order_ok, output bit other_ok, output bit done_ok);
        bit ended = 0;
        lead = 0; act = 0; trail = 0;
        order_ok = 1; other_ok = 1; done_ok = 0;
        @(negedge clk);
        req = 1'b1; req_wr = wr[0]; req_zone = zone[1:0]; ready = (k <= 0);
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (!cs_n) begin
                bit strobe = wr ? !wr_n : !rd_n;
                bit other  = wr ? !rd_n : !wr_n;
                if (other) other_ok = 0;
                if (strobe) begin
                    if (trail > 0) order_ok = 0;
                    act++;
                end else if (act == 0) lead++;
                else trail++;
                ready = (act >= k);
            end else begin
                done_ok = done;
                ended = 1;
                break;
            end
            if (inject && i == 1) begin
                req = 1'b1; req_wr = !wr[0]; req_zone = 2'(zone ^ 1);
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
        end
        req = 1'b0;
        if (!ended) order_ok = 0;
        @(negedge clk);
        if (done || !cs_n) done_ok = 0;
        ready = 1'b1;
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int l, a, t;
        bit ook, sok, dok;
        for (int z = 0; z < NZ; z++) zone_cfg[z*CFG_W +: CFG_W] = pack_zone(z);

        // R11: reset state
        repeat (3) @(negedge clk);
        chk(cs_n && rd_n && wr_n && !done, "R11 reset outputs", {cs_n, rd_n, wr_n, done}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && rd_n && wr_n && !done, "R11 after reset", {cs_n, rd_n, wr_n, done}, 4'b1110);

        // table walk
        for (int v = 0; v < VN; v++) begin
            int wr = V_WR[v], z = V_ZONE[v], k = V_K[v];
            int el = e_lead(wr, z), ea = e_act(wr, z, k), et = e_trail(wr, z);
            string tl, ta;
            tl = (el == 0) ? "R8 lead" : (Z_DBL[z] != 0 ? "R4 lead" : "R3 lead");
            if (Z_RDY[z] != 0) ta = "R5 active";
            else if (k > 0)    ta = "R6 active";
            else               ta = (Z_DBL[z] != 0) ? "R4 active" : "R3 active";
            run_access(wr, z, k, 1'b0, l, a, t, ook, sok, dok);
            chk(l == el, $sformatf("%s vec %0d", tl, v), l, el);
            chk(a == ea, $sformatf("%s vec %0d", ta, v), a, ea);
            chk(t == et, $sformatf("R7 trail vec %0d", v), t, et);
            chk(ook, $sformatf("R1 phase order vec %0d", v), ook, 1);
            chk(sok, $sformatf("R2 other strobe vec %0d", v), sok, 1);
            chk(dok, $sformatf("R9 done pulse vec %0d", v), dok, 1);
        end

        // R10: request raised during an access is ignored
        run_access(0, 1, 0, 1'b1, l, a, t, ook, sok, dok);
        chk(l == e_lead(0, 1) && a == e_act(0, 1, 0) && t == e_trail(0, 1),
            "R10 access unchanged", l*100 + a*10 + t,
            e_lead(0, 1)*100 + e_act(0, 1, 0)*10 + e_trail(0, 1));
        begin
            int lows = 0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (!cs_n) lows++;
            end
            chk(lows == 0, "R10 no second access", lows, 0);
        end

        // R11: reset in mid-access
        @(negedge clk);
        req = 1'b1; req_wr = 1'b0; req_zone = 2'd1; ready = 1'b0;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        chk(!cs_n && !rd_n, "R11 inside active before reset", {cs_n, rd_n}, 2'b00);
        rst_n = 1'b0;
        #1;
        chk(cs_n && rd_n && wr_n && !done, "R11 reset ends access", {cs_n, rd_n, wr_n, done}, 4'b1110);
        @(negedge clk);
        rst_n = 1'b1; ready = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n && rd_n && wr_n && !done, "R11 idle after reset", {cs_n, rd_n, wr_n, done}, 4'b1110);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule